// File: doc/BRIEF.md
# Synthesizer Serial Register Write Master

This block sits on the controller side of a multi-channel frequency synthesizer and writes its registers over a three-wire serial port. A command carries a 5-bit register address, a 32-bit data word and a flag that asks for a commit strobe. The block lowers chip select, clocks out an instruction byte followed by the register payload, most significant bit first, and raises chip select again. The payload length is not supplied by the caller. A fixed table looks it up from the address.

If the commit flag was set, a pulse on the update line follows the release of chip select. The rising edge of that pulse moves the buffered register values into the synthesizer's active registers. After its own reset, the block first runs a power-up sequence on the synthesizer's reset line, and only then accepts commands. Commands use a valid/ready handshake, and the busy output covers the whole transfer, including any update pulse.

Top module: `dds_spi_writer`

## Requirements
- R1: While `rst_n` is low, the outputs are busy=1, cmd_ready=0, cs_n=1, sclk=0, dds_reset=0 and io_update=0. After release, dds_reset stays low for RST_LO_CYC cycles, counted from the release edge, then goes high for RST_HI_CYC cycles, then stays low for RST_TAIL_CYC cycles. Busy is high and cs_n is high throughout this sequence.
- R2: The first eight serial bits of every frame are the instruction byte. Bit 7 is 0 (write), bits 6:5 are 0 and bits 4:0 are the register address. The byte is sent bit 7 first.
- R3: The payload byte count after the instruction is set by the address: 1 at 0x00; 2 at 0x02, 0x05 and 0x07; 3 at 0x01, 0x03 and 0x06; 4 at 0x04 and at every address from 0x08 upward.
- R4: For an N-byte register, the payload is cmd_data[8N-1:0] sent from its most significant bit down. Address 0x06 is the exception: it sends cmd_data[31:8] and drops the low byte.
- R5: At address 0x05 the payload is the 16-bit value {2'b00, cmd_data[13:0]}, so the two top bits of the first payload byte are always 0.
- R6: Each serial bit holds sclk low for DIV_HALF system cycles and then high for DIV_HALF cycles. sdio stays constant over the whole bit and changes only when sclk falls. A frame has exactly 8*(1+N) rising edges.
- R7: cs_n goes low in the cycle after a command is accepted. It stays low for 2*DIV_HALF*8*(1+N) cycles and returns high on the edge where sclk falls for the last time. sclk is low whenever cs_n is high.
- R8: cmd_ready is high only when the block is idle. A valid command presented while busy is ignored and starts no frame. Exactly one frame follows each accepted command.
- R9: If cmd_update was set at acceptance, io_update goes high on the edge that releases cs_n and stays high for UPD_CYC cycles. cs_n stays high during the pulse and busy stays high until the pulse ends.
- R10: Without an update request, io_update stays low, and busy and cmd_ready return to idle on the same edge that releases cs_n. When idle, the outputs are sdio=0, sclk=0, cs_n=1 and dds_reset=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken on this edge if valid |
| cmd_addr | input | 5 | Target register address |
| cmd_data | input | 32 | Register value (alignment per R4/R5) |
| cmd_update | input | 1 | Request commit strobe after the frame |
| busy | output | 1 | Reset sequence, frame or update pulse in progress |
| sclk | output | 1 | Serial clock to synthesizer |
| sdio | output | 1 | Serial data to synthesizer |
| cs_n | output | 1 | Active-low chip select |
| io_update | output | 1 | Commit strobe, active high |
| dds_reset | output | 1 | Synthesizer reset line, active high |

## Verification
The bench builds the block with DIV_HALF=2, UPD_CYC=3 and a reset sequence of 3, 4 and 2 cycles. A two-cycle half period makes the sdio hold inside an sclk phase observable, and it keeps every frame short enough to cover all length classes, the masked phase register, the truncated amplitude register and the high addresses. The short reset and update windows let the bench follow the power-up sequence and the commit pulse cycle by cycle. A command held valid across a whole transfer shows that nothing is accepted while busy. The minimum divider setting of one cycle per phase is not built here.

// File: rtl/dds_wr_pkg.sv
package dds_wr_pkg;

  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 32;
  localparam int INSTR_W = 8;
  localparam int FRAME_W = INSTR_W + DATA_W;

  typedef enum logic [2:0] {
    ST_RLO1  = 3'd0,
    ST_RHI   = 3'd1,
    ST_RTAIL = 3'd2,
    ST_IDLE  = 3'd3,
    ST_SHIFT = 3'd4,
    ST_UPD   = 3'd5
  } wr_state_e;

  // payload byte count per register address
  function automatic logic [2:0] payload_bytes(input logic [ADDR_W-1:0] a);
    logic [2:0] n;
    case (a)
      5'h00:               n = 3'd1;
      5'h02, 5'h05, 5'h07: n = 3'd2;
      5'h01, 5'h03, 5'h06: n = 3'd3;
      default:             n = 3'd4;
    endcase
    return n;
  endfunction

  // instruction byte followed by payload, left aligned, zero filled
  function automatic logic [FRAME_W-1:0] build_frame(input logic [ADDR_W-1:0] a,
                                                     input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] p;
    logic [2:0]        n;
    n = payload_bytes(a);
    if (a == 5'h06) begin
      p = {d[31:8], 8'h00};
    end else begin
      p = (a == 5'h05) ? {18'd0, d[13:0]} : d;
      p = p << (8 * (4 - int'(n)));
    end
    return {{(INSTR_W-ADDR_W){1'b0}}, a, p};
  endfunction

endpackage

// File: rtl/dds_sclk_gen.sv
module dds_sclk_gen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int HW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [HW-1:0] HLAST = HW'(DIV_HALF - 1);

  logic [HW-1:0] hcnt_q, hcnt_d;
  logic          sclk_d;
  logic          wrap;

  always_comb begin
    wrap      = run && (hcnt_q == HLAST);
    rise_tick = wrap && !sclk;
    fall_tick = wrap && sclk;
    if (!run) begin
      hcnt_d = '0;
      sclk_d = 1'b0;
    end else if (wrap) begin
      hcnt_d = '0;
      sclk_d = ~sclk;
    end else begin
      hcnt_d = hcnt_q + 1'b1;
      sclk_d = sclk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      sclk   <= 1'b0;
    end else begin
      hcnt_q <= hcnt_d;
      sclk   <= sclk_d;
    end
  end

endmodule

// File: rtl/dds_shifter.sv
module dds_shifter #(
  parameter int FRAME_W = 40,
  localparam int CW = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_frame,
  input  logic [CW-1:0]      load_bits,
  input  logic               shift,
  output logic               sdio_bit,
  output logic               last_bit
);
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CW-1:0]      left_q, left_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (load) begin
      sh_d   = load_frame;
      left_d = load_bits;
    end else if (shift) begin
      sh_d   = {sh_q[FRAME_W-2:0], 1'b0};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign sdio_bit = sh_q[FRAME_W-1];
  assign last_bit = (left_q == CW'(1));

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |-> (left_q != '0));

endmodule

// File: rtl/dds_cycle_ctr.sv
module dds_cycle_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb cnt_d = clr ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/dds_spi_writer.sv
module dds_spi_writer
  import dds_wr_pkg::*;
#(
  parameter int DIV_HALF     = 2,
  parameter int UPD_CYC      = 4,
  parameter int RST_LO_CYC   = 1024,
  parameter int RST_HI_CYC   = 1024,
  parameter int RST_TAIL_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_update,
  output logic              busy,
  output logic              sclk,
  output logic              sdio,
  output logic              cs_n,
  output logic              io_update,
  output logic              dds_reset
);
  localparam int MAX_AB  = (RST_LO_CYC > RST_HI_CYC) ? RST_LO_CYC : RST_HI_CYC;
  localparam int MAX_CD  = (RST_TAIL_CYC > UPD_CYC) ? RST_TAIL_CYC : UPD_CYC;
  localparam int MAX_W   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TMR_W   = $clog2(MAX_W + 1);
  localparam int FCW     = $clog2(FRAME_W + 1);
  localparam logic [TMR_W-1:0] LO_LAST   = TMR_W'(RST_LO_CYC - 1);
  localparam logic [TMR_W-1:0] HI_LAST   = TMR_W'(RST_HI_CYC - 1);
  localparam logic [TMR_W-1:0] TAIL_LAST = TMR_W'(RST_TAIL_CYC - 1);
  localparam logic [TMR_W-1:0] UPD_LAST  = TMR_W'(UPD_CYC - 1);

  wr_state_e         st_q, st_d;
  logic              upd_q, upd_d;
  logic              accept;
  logic              tmr_clr;
  logic [TMR_W-1:0]  tmr_cnt;
  logic              rise_tick, fall_tick;
  logic              sdio_bit, last_bit;
  logic [FCW-1:0]    frame_bits;
  logic [FRAME_W-1:0] frame;

  assign accept     = cmd_valid && (st_q == ST_IDLE);
  assign frame      = build_frame(cmd_addr, cmd_data);
  assign frame_bits = FCW'(({3'd0, payload_bytes(cmd_addr)} + 6'd1) << 3);

  // next-state process
  always_comb begin
    st_d  = st_q;
    upd_d = upd_q;
    case (st_q)
      ST_RLO1:  if (tmr_cnt == LO_LAST)   st_d = ST_RHI;
      ST_RHI:   if (tmr_cnt == HI_LAST)   st_d = ST_RTAIL;
      ST_RTAIL: if (tmr_cnt == TAIL_LAST) st_d = ST_IDLE;
      ST_IDLE: begin
        if (accept) begin
          st_d  = ST_SHIFT;
          upd_d = cmd_update;
        end
      end
      ST_SHIFT: if (fall_tick && last_bit) st_d = upd_q ? ST_UPD : ST_IDLE;
      ST_UPD:   if (tmr_cnt == UPD_LAST)  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    tmr_clr = (st_d != st_q) || (st_q == ST_IDLE) || (st_q == ST_SHIFT);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RLO1;
      upd_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      upd_q <= upd_d;
    end
  end

  dds_cycle_ctr #(.W(TMR_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .cnt   (tmr_cnt)
  );

  dds_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (st_q == ST_SHIFT),
    .sclk      (sclk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  dds_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_frame (frame),
    .load_bits  (frame_bits),
    .shift      (fall_tick),
    .sdio_bit   (sdio_bit),
    .last_bit   (last_bit)
  );

  assign cmd_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign cs_n      = (st_q != ST_SHIFT);
  assign io_update = (st_q == ST_UPD);
  assign dds_reset = (st_q == ST_RHI);
  assign sdio      = (st_q == ST_SHIFT) && sdio_bit;

  // R7
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R6
  sdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk && $past(sclk)) |-> $stable(sdio));

  // R9
  upd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_update |-> (cs_n && busy));

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!cs_n && busy && !cmd_ready));

  // R1
  rst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dds_reset |-> (busy && cs_n));

endmodule

// File: tb/dds_spi_writer_bench.sv
module dds_spi_writer_bench;
  localparam int H  = 2;
  localparam int U  = 3;
  localparam int T1 = 3;
  localparam int T2 = 4;
  localparam int T3 = 2;
  localparam logic [6:0] IDLE_V = 7'b0110000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [4:0]  cmd_addr;
  logic [31:0] cmd_data;
  logic        cmd_update;
  logic        busy, sclk, sdio, cs_n, io_update, dds_reset;

  always #10 clk = ~clk;

  dds_spi_writer #(
    .DIV_HALF(H), .UPD_CYC(U), .RST_LO_CYC(T1), .RST_HI_CYC(T2), .RST_TAIL_CYC(T3)
  ) u_dds_spi_writer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_update(cmd_update),
    .busy(busy), .sclk(sclk), .sdio(sdio), .cs_n(cs_n),
    .io_update(io_update), .dds_reset(dds_reset)
  );

  // expected tuple: {busy, ready, cs_n, sclk, sdio, io_update, dds_reset}
  logic [6:0] exp_q[$];
  string      tag_q[$];
  int checks = 0;
  int fails  = 0;
  bit mon_en = 1'b0;
  int cs_low, rises, upd_hi, cs_falls;
  logic prev_sclk = 1'b0;
  logic prev_cs   = 1'b1;

  task automatic chk(input bit ok, input string t, input int got, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", t, got, expv);
    end
  endtask

  function automatic int blen(input int a);
    if (a == 0) return 1;
    if (a == 2 || a == 5 || a == 7) return 2;
    if (a == 1 || a == 3 || a == 6) return 3;
    return 4;
  endfunction

  task automatic push(input logic [6:0] v, input string t, input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v);
      tag_q.push_back(t);
    end
  endtask

  task automatic push_bit(input logic b, input string t);
    push({1'b1, 1'b0, 1'b0, 1'b0, b, 1'b0, 1'b0}, t, H);
    push({1'b1, 1'b0, 1'b0, 1'b1, b, 1'b0, 1'b0}, t, H);
  endtask

  task automatic push_cmd(input int a, input logic [31:0] d, input bit up);
    logic [31:0] p;
    int n;
    string t;
    n = blen(a);
    for (int i = 7; i >= 0; i--) push_bit(((a >> i) & 1) != 0, "R2");
    if (a == 6)      begin p = d >> 8;            t = "R4"; end
    else if (a == 5) begin p = d & 32'h0000_3FFF; t = "R5"; end
    else             begin p = d;                 t = "R3"; end
    for (int i = 8 * n - 1; i >= 0; i--) push_bit(p[i], t);
    if (up) push(7'b1010010, "R9", U);
  endtask

  always @(negedge clk) begin
    logic [6:0] got, e;
    string t;
    if (mon_en) begin
      got = {busy, cmd_ready, cs_n, sclk, sdio, io_update, dds_reset};
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
      end else begin
        e = IDLE_V;
        t = "R10";
      end
      chk(got === e, t, int'(got), int'(e));
      if (!cs_n) cs_low++;
      if (sclk && !prev_sclk) rises++;
      if (io_update) upd_hi++;
      if (!cs_n && prev_cs) cs_falls++;
      prev_sclk = sclk;
      prev_cs   = cs_n;
    end
  end

  task automatic clear_ctrs();
    cs_low = 0; rises = 0; upd_hi = 0; cs_falls = 0;
  endtask

  task automatic wait_empty();
    while (exp_q.size() != 0) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic frame_checks(input int a, input bit up, input int nframes);
    int n;
    n = blen(a);
    chk(cs_low == nframes * 2 * H * 8 * (1 + n), "R7", cs_low, nframes * 2 * H * 8 * (1 + n));
    chk(rises == nframes * 8 * (1 + n), "R6", rises, nframes * 8 * (1 + n));
    chk(upd_hi == (up ? U : 0), up ? "R9" : "R10", upd_hi, up ? U : 0);
    chk(cs_falls == nframes, "R8", cs_falls, nframes);
  endtask

  task automatic send(input int a, input logic [31:0] d, input bit up);
    @(negedge clk);
    #1;
    cmd_addr = 5'(a); cmd_data = d; cmd_update = up; cmd_valid = 1'b1;
    clear_ctrs();
    push_cmd(a, d, up);
    @(negedge clk);
    #1;
    cmd_valid = 1'b0;
    wait_empty();
    #1;
    frame_checks(a, up, 1);
  endtask

  // R8: second command held valid for the whole transfer must be ignored
  task automatic send_hold(input int a, input logic [31:0] d, input bit up);
    @(negedge clk);
    #1;
    cmd_addr = 5'(a); cmd_data = d; cmd_update = up; cmd_valid = 1'b1;
    clear_ctrs();
    push_cmd(a, d, up);
    @(negedge clk);
    #1;
    cmd_addr = 5'h04; cmd_data = 32'hFFFF_FFFF; cmd_update = 1'b1;
    wait_empty();
    @(negedge clk);
    #1;
    cmd_valid = 1'b0;
    frame_checks(a, up, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_data = '0; cmd_update = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk({busy, cmd_ready, cs_n, sclk, dds_reset, io_update} === 6'b101000, "R1",
        int'({busy, cmd_ready, cs_n, sclk, dds_reset, io_update}), 'b101000);
    push(7'b1010000, "R1", T1 - 1);
    push(7'b1010001, "R1", T2);
    push(7'b1010000, "R1", T3);
    mon_en = 1'b1;
    rst_n  = 1'b1;
    wait_empty();

    send(0,  32'h1234_56A5, 1'b0);
    send(1,  32'h77C3_5A96, 1'b1);
    send(2,  32'hABCD_1234, 1'b0);
    send(3,  32'h0081_8181, 1'b0);
    send(4,  32'hDEAD_BEEF, 1'b1);
    send(5,  32'h0000_FFFF, 1'b0);
    send(5,  32'h1234_8001, 1'b1);
    send(6,  32'h89AB_CDEF, 1'b0);
    send(7,  32'h0000_0180, 1'b0);
    send(8,  32'h8000_0001, 1'b0);
    send(24, 32'h0F0F_F0F0, 1'b1);
    send(31, 32'h5555_AAAA, 1'b0);
    send_hold(2, 32'h0000_C001, 1'b1);
    send_hold(6, 32'h0102_0304, 1'b0);
    send(4,  32'h0000_0000, 1'b0);
    repeat (4) @(negedge clk);
    #1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule